// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array

A small two-dimensional mesh of one-bit processing elements. All elements run the same instruction in the same cycle, taken from a single controller port. Each element has three one-bit working registers (X, Y and a carry register C), an activity flag, a full adder and its own local bit memory. Words of any width are handled one bit per instruction, least significant bit first. A w-bit addition therefore costs w add instructions after one carry-clear.

Elements pass one bit per cycle to a mesh neighbour. Bits that enter from outside the array edge take a fill value supplied by the controller. The array does not wrap around. The controller reads back global results in two ways. Row and column responses OR a selected register over the active elements. A pipelined adder tree counts the set bits of a memory bit plane over the active elements. Clearing an element's activity flag masks its memory writes and takes it out of both global results.

Top module: `simd_array`

## Requirements
- R1: After reset, every X, Y and C register and every memory bit is 0, every activity flag is 1, and `count_valid_o` is 0.
- R2: The instruction word is {op[3:0], sel[1:0], addr[5:0]}, with op in bits 11:8, sel in bits 7:6 and addr in bits 5:0. The op codes are: 0 no-op, 1 reg<=mem, 2 reg<=scalar, 3 mem<=reg, 4 add, 5 clear carry, 6 AND, 7 OR, 8 XOR, 9 invert reg, 10 shift north, 11 shift east, 12 shift west, 13 shift south, 14 activity<=reg, 15 count. The sel codes are 0 X, 1 Y, 2 C.
- R3: Load, store and the logic ops act on the selected register. AND, OR and XOR combine that register with mem[addr] and write the result back to the same register. Each instruction completes in the cycle it is issued.
- R4: Add computes X + mem[addr] + C. The sum bit goes to mem[addr] and the carry-out goes to C. Clear-carry sets C to 0 in every element.
- R5: An element whose activity flag is 0 keeps its memory unchanged on store and add. Its registers still update.
- R6: A shift moves the selected register one element in the named direction. Row 0 is the north edge and column 0 is the west edge. The element on the entering edge takes `fill_i`. Nothing wraps around.
- R7: `row_resp_o[r]` and `col_resp_o[c]` are, within the same cycle, the OR over the active elements of that row or column of the register selected by the current sel field.
- R8: A count instruction yields the number of active elements whose mem[addr] is 1. The result appears on `count_o` with `count_valid_o` high for one cycle, 6 clock edges after issue. Back-to-back requests are accepted.
- R9: sel code 3 selects X for every operation and for the responses.
- R10: Operand width is not fixed: an 8-bit sum is formed by one clear-carry and 8 add instructions over 8 memory bit planes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 12 | Broadcast instruction word |
| scalar_i | input | 1 | Broadcast scalar bit for load-scalar |
| fill_i | input | 1 | Value shifted in at the array edge |
| row_resp_o | output | 8 | Per-row OR of the selected register over active elements |
| col_resp_o | output | 8 | Per-column OR of the selected register over active elements |
| count_o | output | 7 | Population count result |
| count_valid_o | output | 1 | Count result valid strobe |

## Verification
The assertions check every cycle that:
- a masked store or add leaves an element's memory unchanged;
- clear-carry empties the carry;
- the edge column and edge row take the fill value on east and south shifts;
- the row and column responses agree on whether any element responds, and both are silent when no element is active;
- a delivered count never exceeds the element count.

Only the bench scenarios can show the remaining behaviour. These are the arithmetic value of a multi-bit bit-serial sum, the exact pipeline latency of the count, and the absence of wrap-around on west and north shifts. They also show that inactive elements kept their old memory: this is only visible once the activity flags are restored and the plane is counted again.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int OPW  = 4;
  localparam int SELW = 2;

  typedef enum logic [OPW-1:0] {
    OP_NOP    = 4'd0,
    OP_LDM    = 4'd1,
    OP_LDS    = 4'd2,
    OP_STM    = 4'd3,
    OP_ADD    = 4'd4,
    OP_CLC    = 4'd5,
    OP_AND    = 4'd6,
    OP_OR     = 4'd7,
    OP_XOR    = 4'd8,
    OP_NOT    = 4'd9,
    OP_SHN    = 4'd10,
    OP_SHE    = 4'd11,
    OP_SHW    = 4'd12,
    OP_SHS    = 4'd13,
    OP_SETACT = 4'd14,
    OP_CNT    = 4'd15
  } op_e;
endpackage

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  op_e                 op_i,
  input  logic [SELW-1:0]     sel_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                scalar_i,
  input  logic                nb_n_i,
  input  logic                nb_e_i,
  input  logic                nb_w_i,
  input  logic                nb_s_i,
  output logic                x_o,
  output logic                y_o,
  output logic                c_o,
  output logic                act_o,
  output logic                mem_bit_o
);
  localparam int DEPTH = 1 << AW;

  logic             x_q, y_q, c_q, act_q;
  logic [DEPTH-1:0] mem_q;
  logic             cur, m, sum, cout;
  logic             wr_en, wr_val, mem_we, mem_val;

  always_comb begin
    case (sel_i)
      2'd1:    cur = y_q;
      2'd2:    cur = c_q;
      default: cur = x_q;  // code 3 aliases X
    endcase
    m    = mem_q[addr_i];
    sum  = x_q ^ m ^ c_q;
    cout = (x_q & m) | (x_q & c_q) | (m & c_q);
    wr_en   = 1'b1;
    wr_val  = cur;
    mem_we  = 1'b0;
    mem_val = cur;
    case (op_i)
      OP_LDM: wr_val = m;
      OP_LDS: wr_val = scalar_i;
      OP_AND: wr_val = cur & m;
      OP_OR:  wr_val = cur | m;
      OP_XOR: wr_val = cur ^ m;
      OP_NOT: wr_val = ~cur;
      OP_SHN: wr_val = nb_s_i;  // data travels north, so it comes from the south
      OP_SHE: wr_val = nb_w_i;
      OP_SHW: wr_val = nb_e_i;
      OP_SHS: wr_val = nb_n_i;
      OP_STM: begin wr_en = 1'b0; mem_we = act_q; end
      OP_ADD: begin wr_en = 1'b0; mem_we = act_q; mem_val = sum; end
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= 1'b0;
      y_q   <= 1'b0;
      c_q   <= 1'b0;
      act_q <= 1'b1;
      mem_q <= '0;
    end else begin
      if (wr_en) begin
        case (sel_i)
          2'd1:    y_q <= wr_val;
          2'd2:    c_q <= wr_val;
          default: x_q <= wr_val;
        endcase
      end
      if (op_i == OP_ADD)    c_q   <= cout;
      if (op_i == OP_CLC)    c_q   <= 1'b0;
      if (op_i == OP_SETACT) act_q <= cur;
      if (mem_we)            mem_q[addr_i] <= mem_val;
    end
  end

  assign x_o       = x_q;
  assign y_o       = y_q;
  assign c_o       = c_q;
  assign act_o     = act_q;
  assign mem_bit_o = m;

  p_clc_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLC) |=> !c_q);

  p_masked_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && (op_i == OP_STM || op_i == OP_ADD)) |=> (mem_q == $past(mem_q)));
endmodule

// File: rtl/simd_popcnt.sv
module simd_popcnt #(
  parameter int N = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N-1:0]           bits_i,
  input  logic                   req_i,
  output logic [$clog2(N):0]     count_o,
  output logic                   valid_o
);
  localparam int LV = $clog2(N);
  localparam int CW = LV + 1;

  logic [CW-1:0] leaf [N];
  logic [CW-1:0] node [1:N-1];
  logic [LV-1:0] vld_q;

  initial assert (N == (1 << LV) && LV >= 2);

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign leaf[i] = CW'(bits_i[i]);
  end

  // heap-ordered tree, one register stage per level
  for (genvar i = 1; i < N; i++) begin : g_node
    logic [CW-1:0] lhs, rhs;
    if (2 * i >= N) begin : g_bot
      assign lhs = leaf[2*i-N];
      assign rhs = leaf[2*i+1-N];
    end else begin : g_mid
      assign lhs = node[2*i];
      assign rhs = node[2*i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) node[i] <= '0;
      else         node[i] <= lhs + rhs;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LV-2:0], req_i};
  end

  assign count_o = node[1];
  assign valid_o = vld_q[LV-1];

  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (count_o <= CW'(N)));
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int AW   = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [OPW+SELW+AW-1:0]            instr_i,
  input  logic                              scalar_i,
  input  logic                              fill_i,
  output logic [ROWS-1:0]                   row_resp_o,
  output logic [COLS-1:0]                   col_resp_o,
  output logic [$clog2(ROWS*COLS):0]        count_o,
  output logic                              count_valid_o
);
  localparam int N  = ROWS * COLS;
  localparam int IW = OPW + SELW + AW;

  op_e             op;
  logic [SELW-1:0] sel;
  logic [AW-1:0]   addr;

  assign op   = op_e'(instr_i[IW-1 -: OPW]);
  assign sel  = instr_i[AW +: SELW];
  assign addr = instr_i[AW-1:0];

  logic [N-1:0] x_v, y_v, c_v, act_v, mem_v, sb_v, hit_v;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int E = r * COLS + c;
      logic nb_n, nb_e, nb_w, nb_s;

      if (r == 0)        begin : g_n_edge assign nb_n = fill_i;              end
      else               begin : g_n_in   assign nb_n = sb_v[E-COLS];        end
      if (r == ROWS - 1) begin : g_s_edge assign nb_s = fill_i;              end
      else               begin : g_s_in   assign nb_s = sb_v[E+COLS];        end
      if (c == 0)        begin : g_w_edge assign nb_w = fill_i;              end
      else               begin : g_w_in   assign nb_w = sb_v[E-1];           end
      if (c == COLS - 1) begin : g_e_edge assign nb_e = fill_i;              end
      else               begin : g_e_in   assign nb_e = sb_v[E+1];           end

      assign sb_v[E] = (sel == 2'd1) ? y_v[E] : (sel == 2'd2) ? c_v[E] : x_v[E];

      simd_pe #(.AW(AW)) u_pe (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .op_i      (op),
        .sel_i     (sel),
        .addr_i    (addr),
        .scalar_i  (scalar_i),
        .nb_n_i    (nb_n),
        .nb_e_i    (nb_e),
        .nb_w_i    (nb_w),
        .nb_s_i    (nb_s),
        .x_o       (x_v[E]),
        .y_o       (y_v[E]),
        .c_o       (c_v[E]),
        .act_o     (act_v[E]),
        .mem_bit_o (mem_v[E])
      );
    end

    p_fill_east_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_SHE && sel == 2'd0) |=> (x_v[r*COLS] == $past(fill_i)));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_edge_col
    p_fill_south_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_SHS && sel == 2'd0) |=> (x_v[c] == $past(fill_i)));
  end

  assign hit_v = sb_v & act_v;

  always_comb begin
    row_resp_o = '0;
    col_resp_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        row_resp_o[r] = row_resp_o[r] | hit_v[r*COLS+c];
        col_resp_o[c] = col_resp_o[c] | hit_v[r*COLS+c];
      end
    end
  end

  simd_popcnt #(.N(N)) u_popcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bits_i  (mem_v & act_v),
    .req_i   (op == OP_CNT),
    .count_o (count_o),
    .valid_o (count_valid_o)
  );

  p_resp_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|row_resp_o) == (|col_resp_o));

  p_idle_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_v == '0) |-> (row_resp_o == '0 && col_resp_o == '0));
endmodule

// File: tb/simd_array_bench.sv
module simd_array_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] instr_i = '0;
  logic        scalar_i = 1'b0;
  logic        fill_i = 1'b0;
  logic [7:0]  row_resp_o, col_resp_o;
  logic [6:0]  count_o;
  logic        count_valid_o;

  always #4 clk_i = ~clk_i;

  simd_array u_simd_array (
    .clk_i, .rst_ni, .instr_i, .scalar_i, .fill_i,
    .row_resp_o, .col_resp_o, .count_o, .count_valid_o
  );

  int    total = 0;
  int    bad = 0;
  string tag = "R1";

  // reference state, element index = row*8 + col
  bit        mx [64];
  bit        my [64];
  bit        mc [64];
  bit        ma [64];
  bit [63:0] mm [64];
  bit        pv [6];
  int        pc [6];
  logic [7:0] row_seen, col_seen;

  task automatic chk(string t, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", t, got, exp);
    end
  endtask

  function automatic bit msel(int e, int s);
    return (s == 1) ? my[e] : (s == 2) ? mc[e] : mx[e];
  endfunction

  task automatic model_reset();
    for (int e = 0; e < 64; e++) begin
      mx[e] = 0; my[e] = 0; mc[e] = 0; ma[e] = 1; mm[e] = '0;
    end
    for (int i = 0; i < 6; i++) begin pv[i] = 0; pc[i] = 0; end
  endtask

  task automatic model_apply(logic [11:0] ins, bit sc, bit fl);
    int op = ins[11:8];
    int s  = ins[7:6];
    int a  = ins[5:0];
    bit ob [64];
    bit m  [64];
    for (int e = 0; e < 64; e++) begin ob[e] = msel(e, s); m[e] = mm[e][a]; end
    for (int e = 0; e < 64; e++) begin
      int r = e / 8;
      int c = e % 8;
      bit v;
      bit w = 1;
      case (op)
        1:  v = m[e];
        2:  v = sc;
        6:  v = ob[e] & m[e];
        7:  v = ob[e] | m[e];
        8:  v = ob[e] ^ m[e];
        9:  v = ~ob[e];
        10: v = (r == 7) ? fl : ob[e+8];
        11: v = (c == 0) ? fl : ob[e-1];
        12: v = (c == 7) ? fl : ob[e+1];
        13: v = (r == 0) ? fl : ob[e-8];
        default: begin v = 0; w = 0; end
      endcase
      if (w) begin
        if (s == 1) my[e] = v; else if (s == 2) mc[e] = v; else mx[e] = v;
      end
      if (op == 3 && ma[e]) mm[e][a] = ob[e];
      if (op == 4) begin
        bit sm = mx[e] ^ m[e] ^ mc[e];
        bit co = (mx[e] & m[e]) | (mx[e] & mc[e]) | (m[e] & mc[e]);
        if (ma[e]) mm[e][a] = sm;
        mc[e] = co;
      end
      if (op == 5)  mc[e] = 0;
      if (op == 14) ma[e] = ob[e];
    end
  endtask

  task automatic step(int op, int s, int a, bit sc, bit fl);
    logic [11:0] ins = {op[3:0], s[1:0], a[5:0]};
    logic [7:0]  er = '0;
    logic [7:0]  ec = '0;
    int          cnt = 0;
    @(negedge clk_i);
    instr_i = ins; scalar_i = sc; fill_i = fl;
    #1;
    for (int e = 0; e < 64; e++) begin
      if (msel(e, s) & ma[e]) begin er[e/8] = 1'b1; ec[e%8] = 1'b1; end
      if (mm[e][a] & ma[e]) cnt++;
    end
    row_seen = row_resp_o;
    col_seen = col_resp_o;
    chk({tag, " R7 row response"}, row_resp_o, er);
    chk({tag, " R7 col response"}, col_resp_o, ec);
    @(posedge clk_i);
    model_apply(ins, sc, fl);
    for (int i = 5; i > 0; i--) begin pv[i] = pv[i-1]; pc[i] = pc[i-1]; end
    pv[0] = (op == 15);
    pc[0] = cnt;
    #1;
    chk({tag, " R8 count valid"}, count_valid_o, pv[5]);
    if (pv[5]) chk({tag, " R8 count value"}, count_o, pc[5]);
  endtask

  // issue a count and wait until its result is on the port
  task automatic expect_plane(string t, int a, int exp);
    step(15, 0, a, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);
    chk({t, " plane count"}, count_o, exp);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset values
    chk("R1 count_valid in reset", count_valid_o, 0);
    chk("R1 row response in reset", row_resp_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    tag = "R1";
    expect_plane("R1 memory cleared", 0, 0);
    step(2, 0, 0, 1, 0);
    step(3, 0, 1, 0, 0);
    expect_plane("R1 all active", 1, 64);

    // R2 field positions and R9 alias: sel 3 writes and reads X
    tag = "R9";
    step(2, 0, 0, 0, 0);
    step(2, 3, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    chk("R9 sel3 loads X", row_seen, 8'hff);
    step(0, 3, 0, 0, 0);
    chk("R2 R9 sel3 reads X", col_seen, 8'hff);

    // R4 / R10: 8-bit bit-serial add, LSB first
    tag = "R4";
    begin
      bit [7:0] a = 8'($urandom);
      bit [7:0] b = 8'($urandom);
      bit [8:0] sm = a + b;
      for (int i = 0; i < 8; i++) begin step(2, 0, 0, a[i], 0); step(3, 0, i, 0, 0); end
      for (int i = 0; i < 8; i++) begin step(2, 0, 0, b[i], 0); step(3, 0, 8 + i, 0, 0); end
      step(5, 2, 0, 0, 0);
      for (int i = 0; i < 8; i++) begin step(1, 0, i, 0, 0); step(4, 0, 8 + i, 0, 0); end
      for (int i = 0; i < 8; i++) expect_plane("R10 sum bit", 8 + i, sm[i] ? 64 : 0);
      step(0, 2, 0, 0, 0);
      chk("R4 carry out", row_seen, sm[8] ? 8'hff : 8'h00);
      step(5, 0, 0, 0, 0);
      step(0, 2, 0, 0, 0);
      chk("R4 carry cleared", row_seen, 0);
    end

    // R5: activity mask on writes
    tag = "R5";
    begin
      bit [7:0] pat = 8'b1011_0010;
      for (int k = 0; k < 8; k++) step(11, 0, 0, 0, pat[k]);
      step(14, 0, 0, 0, 0);
      step(2, 0, 0, 1, 0);
      step(3, 0, 20, 0, 0);
      expect_plane("R5 active written", 20, 32);
      step(14, 0, 0, 0, 0);
      expect_plane("R5 inactive kept", 20, 32);
    end

    // R6: edge fill and no wrap
    tag = "R6";
    step(2, 0, 0, 0, 0);
    step(11, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    chk("R6 east fill column 0", col_seen, 8'h01);
    step(12, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R6 west no wrap", col_seen, 8'h00);
    step(10, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    chk("R6 north fill row 7", row_seen, 8'h80);
    step(13, 0, 0, 0, 0);
    step(13, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R6 south no wrap", row_seen, 8'h00);

    // R8: back-to-back counts on different planes
    tag = "R8";
    step(15, 0, 8, 0, 0);
    step(15, 0, 20, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0);

    // R3 and everything else: random stream against the reference
    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 16);
      if (op == 14 && ($urandom % 3) != 0) op = 0;
      step(op, int'($urandom % 4), int'($urandom % 64), 1'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule